// File: doc/BRIEF.md
# Board Control Register File

This block is the control and status register space of a development board. A processor reaches it over a simple single-cycle bus: a valid strobe, a write flag, a 20-bit byte offset, 32-bit write data and registered 32-bit read data. Writes set an 8-LED bar, an eight-character ASCII display buffer, a general output byte and a break/reset byte. Writes can also raise a soft-reset request pulse and drive the clock and data lines of a bit-banged I2C link to a serial EEPROM. Reads return these values, a few fixed identification words, and the EEPROM's data line.

The display buffer can be loaded in two ways. A single word write turns a 32-bit value into eight uppercase hexadecimal characters. Each character also has its own register, and these sit 8 bytes apart. When any character actually changes, a one-cycle update strobe tells the renderer downstream to redraw.

Offsets that are not mapped read as zero, and writes to them are dropped.

Top module: `brdctl_regs`

## Requirements
- R1: All 20 offset bits are decoded. An offset that matches a mapped register only in its low 12 bits (for example 0x10408) reads zero and ignores writes, the same as any other unmapped offset.
- R2: Offsets 0x200 (switches) and 0x210 (jumpers) always read 0. Writes to them, and writes to the read-only status word, change nothing.
- R3: Offset 0x208 reads 0x12 when parameter BIG_ENDIAN is 1 (the default) and 0x10 when it is 0.
- R4: A write to offset 0x408 stores bits 7:0 of the data on `led_bar`. A read of 0x408 returns that byte zero-extended. The reset value is 0.
- R5: A write to offset 0x410 loads all eight display characters from the 32-bit data. Character position k (byte k of `disp_chars`, bits 8k+7:8k) takes nibble bits 31-4k:28-4k. The nibble is encoded as ASCII '0'-'9' (0x30-0x39) or uppercase 'A'-'F' (0x41-0x46).
- R6: A write to offset 0x418 + 8k (k = 0..7) stores data bits 7:0 into character k only. Offsets in that range that are not a multiple of 8, and offset 0x458, are ignored.
- R7: `sys_rst_req` is high for exactly the one cycle after a write of exactly 0x00000042 to offset 0x500. Any other value written there, including 0x142, leaves it low.
- R8: Offset 0x508 is an 8-bit break register with reset value 0x0A. Offset 0xA00 is an 8-bit general output register with reset value 0x00. Both keep data bits 7:0 and read back zero-extended.
- R9: Offset 0xB08 keeps data bits 1:0 as the pin enable (reset 0). Offset 0xB18 keeps bit 0 as the loopback select (reset 1). Both read back.
- R10: Offset 0xB10 stores the full 32-bit word, with reset value 3. Bit 1 drives `i2c_scl` and bit 0 drives `i2c_sda`, both effective the cycle after the write. A read returns the stored word.
- R11: A read of offset 0xB00 returns 0x2 with bit 0 replaced by `eeprom_sda` as sampled in the request cycle.
- R12: A read of offset 0xA08 returns the I2C out word (R10) while the select bit (R9) is 1, and 0 while it is 0.
- R13: At reset all display characters are 0x20. `disp_upd` is high for one cycle after, and only after, a write that changes at least one character.
- R14: Read data appears on `bus_rdata` in the cycle after a read request and holds until the next read. Writes do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_bar | output | 8 | LED bar state |
| disp_chars | output | 64 | Display characters, position k at bits 8k+7:8k |
| disp_upd | output | 1 | Display changed strobe |
| gp_out | output | 8 | General output byte |
| brk_val | output | 8 | Break/reset byte |
| sys_rst_req | output | 1 | Soft-reset request pulse |
| i2c_oe | output | 2 | I2C pin enable bits |
| i2c_sel | output | 1 | Loopback select |
| i2c_scl | output | 1 | Clock line to the EEPROM |
| i2c_sda | output | 1 | Data line to the EEPROM |
| eeprom_sda | input | 1 | Data line from the EEPROM |

## Verification
Every stored field drives a port directly, so a corrupted field shows up on its output pin in the first cycle after the write that set it. A wrong decode shows up in one of two ways: a field moves after a write aimed at another offset, or a read returns data one cycle later that does not match the write. Either is visible within two cycles. A bad display update mask shows up as a strobe without a character change, or a change without a strobe, in the same cycle the characters load.

// File: rtl/brdctl_regs.sv
module brdctl_regs #(
  parameter int  AW         = 20,
  parameter int  DW         = 32,
  parameter int  NCHAR      = 8,
  parameter bit  BIG_ENDIAN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_vld,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [7:0]         led_bar,
  output logic [8*NCHAR-1:0] disp_chars,
  output logic               disp_upd,
  output logic [7:0]         gp_out,
  output logic [7:0]         brk_val,
  output logic               sys_rst_req,
  output logic [1:0]         i2c_oe,
  output logic               i2c_sel,
  output logic               i2c_scl,
  output logic               i2c_sda,
  input  logic               eeprom_sda
);

  localparam int          IDX_W     = (NCHAR > 1) ? $clog2(NCHAR) : 1;
  localparam logic [AW-1:0] O_SWITCH = AW'('h200);
  localparam logic [AW-1:0] O_STATUS = AW'('h208);
  localparam logic [AW-1:0] O_JUMPER = AW'('h210);
  localparam logic [AW-1:0] O_LED    = AW'('h408);
  localparam logic [AW-1:0] O_WORD   = AW'('h410);
  localparam logic [AW-1:0] O_POS0   = AW'('h418);
  localparam logic [AW-1:0] O_POSN   = O_POS0 + AW'(8 * (NCHAR - 1));
  localparam logic [AW-1:0] O_SOFT   = AW'('h500);
  localparam logic [AW-1:0] O_BRK    = AW'('h508);
  localparam logic [AW-1:0] O_GPO    = AW'('hA00);
  localparam logic [AW-1:0] O_GPI    = AW'('hA08);
  localparam logic [AW-1:0] O_I2CIN  = AW'('hB00);
  localparam logic [AW-1:0] O_I2COE  = AW'('hB08);
  localparam logic [AW-1:0] O_I2COUT = AW'('hB10);
  localparam logic [AW-1:0] O_I2CSEL = AW'('hB18);
  localparam logic [DW-1:0] MAGIC    = DW'('h42);
  localparam logic [DW-1:0] IN_BASE  = DW'('h3);
  localparam logic [DW-1:0] STAT_VAL = BIG_ENDIAN ? DW'('h12) : DW'('h10);
  localparam logic [7:0]    SPACE    = 8'h20;

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'd0, n}) : (8'h37 + {4'd0, n});
  endfunction

  logic          wr_en, rd_en;
  logic          wr_word, wr_pos;
  logic [AW-1:0] pos_diff;
  logic [IDX_W-1:0] pos_idx;
  logic [DW-1:0] i2c_out;
  logic [8*NCHAR-1:0] chars_nxt;
  logic [DW-1:0] rd_mux;

  assign wr_en    = bus_vld &  bus_wr;
  assign rd_en    = bus_vld & ~bus_wr;
  assign wr_word  = wr_en && bus_addr == O_WORD;
  assign pos_diff = bus_addr - O_POS0;
  assign pos_idx  = pos_diff[3 +: IDX_W];
  assign wr_pos   = wr_en && bus_addr >= O_POS0 && bus_addr <= O_POSN && bus_addr[2:0] == 3'd0;
  assign i2c_scl  = i2c_out[1];
  assign i2c_sda  = i2c_out[0];

  for (genvar g = 0; g < NCHAR; g++) begin : g_char
    logic [7:0] cur;
    assign cur = disp_chars[8*g +: 8];
    always_comb begin
      chars_nxt[8*g +: 8] = cur;
      if (wr_word)
        chars_nxt[8*g +: 8] = hex_ascii(bus_wdata[DW-1-4*g -: 4]);
      else if (wr_pos && pos_idx == IDX_W'(g))
        chars_nxt[8*g +: 8] = bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_chars <= {NCHAR{SPACE}};
      disp_upd   <= 1'b0;
    end else begin
      disp_chars <= chars_nxt;
      disp_upd   <= (chars_nxt != disp_chars);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_bar     <= 8'h00;
      brk_val     <= 8'h0A;
      gp_out      <= 8'h00;
      i2c_oe      <= 2'b00;
      i2c_sel     <= 1'b1;
      i2c_out     <= DW'('h3);
      sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= wr_en && bus_addr == O_SOFT && bus_wdata == MAGIC;
      if (wr_en) begin
        case (bus_addr)
          O_LED:    led_bar <= bus_wdata[7:0];
          O_BRK:    brk_val <= bus_wdata[7:0];
          O_GPO:    gp_out  <= bus_wdata[7:0];
          O_I2COE:  i2c_oe  <= bus_wdata[1:0];
          O_I2CSEL: i2c_sel <= bus_wdata[0];
          O_I2COUT: i2c_out <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      O_SWITCH: rd_mux = '0;
      O_JUMPER: rd_mux = '0;
      O_STATUS: rd_mux = STAT_VAL;
      O_LED:    rd_mux = {{(DW-8){1'b0}}, led_bar};
      O_BRK:    rd_mux = {{(DW-8){1'b0}}, brk_val};
      O_GPO:    rd_mux = {{(DW-8){1'b0}}, gp_out};
      O_GPI:    rd_mux = i2c_sel ? i2c_out : '0;
      O_I2CIN:  rd_mux = {IN_BASE[DW-1:1], eeprom_sda};
      O_I2COE:  rd_mux = {{(DW-2){1'b0}}, i2c_oe};
      O_I2COUT: rd_mux = i2c_out;
      O_I2CSEL: rd_mux = {{(DW-1){1'b0}}, i2c_sel};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (rd_en)
      bus_rdata <= rd_mux;
  end

  AST_SOFT_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(bus_vld && bus_wr && bus_addr == O_SOFT && bus_wdata == MAGIC)); // R7
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && bus_wr && bus_addr == O_LED) |=> $stable(led_bar)); // R4
  AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_chars) |-> disp_upd); // R13
  AST_UPD_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_upd |-> !$stable(disp_chars)); // R13
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && bus_wr && bus_addr == O_I2COUT) |=> $stable({i2c_scl, i2c_sda})); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_wr) |=> $stable(bus_rdata)); // R14

endmodule

// File: tb/brdctl_regs_test.sv
module brdctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0, bus_wr = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_bar, gp_out, brk_val;
  logic [63:0] disp_chars;
  logic        disp_upd, sys_rst_req, i2c_sel, i2c_scl, i2c_sda;
  logic [1:0]  i2c_oe;
  logic        eeprom_sda = 1'b1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  brdctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_bar(led_bar), .disp_chars(disp_chars), .disp_upd(disp_upd),
    .gp_out(gp_out), .brk_val(brk_val), .sys_rst_req(sys_rst_req),
    .i2c_oe(i2c_oe), .i2c_sel(i2c_sel), .i2c_scl(i2c_scl), .i2c_sda(i2c_sda),
    .eeprom_sda(eeprom_sda)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_vld = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n <= 4'd9) ? 8'h30 + 8'(n) : 8'h41 + 8'(n - 4'd10);
  endfunction

  function automatic logic [63:0] hex_chars(input logic [31:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = hx(v[31-4*k -: 4]);
    return r;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R4 led reset", led_bar, 0);
    chk("R8 brk reset", brk_val, 8'h0A);
    chk("R8 gp reset", gp_out, 0);
    chk("R9 oe reset", i2c_oe, 0);
    chk("R9 sel reset", i2c_sel, 1);
    chk("R10 scl/sda reset", {i2c_scl, i2c_sda}, 2'b11);
    chk("R13 chars reset", disp_chars, {8{8'h20}});
    chk("R13 upd reset", disp_upd, 0);
    chk("R7 req reset", sys_rst_req, 0);
    rd(20'h508, d); chk("R8 brk read", d, 32'h0A);
    rd(20'hB10, d); chk("R10 out read reset", d, 32'h3);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr(20'h200, 32'hFFFF_FFFF); wr(20'h210, 32'hFFFF_FFFF); wr(20'h208, 32'h0);
    rd(20'h200, d); chk("R2 switch", d, 0);
    rd(20'h210, d); chk("R2 jumper", d, 0);
    rd(20'h208, d); chk("R3 status", d, 32'h12);
    wr(20'h10408, 32'h5A);
    chk("R1 alias write", led_bar, 0);
    rd(20'h10408, d); chk("R1 alias read", d, 0);
    rd(20'h300, d); chk("R1 unmapped read", d, 0);
  endtask

  task automatic t_led;
    logic [31:0] d;
    wr(20'h408, 32'h1234_56A5);
    chk("R4 led pin", led_bar, 8'hA5);
    rd(20'h408, d); chk("R4 led read", d, 32'hA5);
  endtask

  task automatic t_hex;
    wr(20'h410, 32'hDEAD_BEEF);
    chk("R5 hex chars", disp_chars, hex_chars(32'hDEAD_BEEF));
    chk("R5 char0 is D", disp_chars[7:0], 8'h44);
    chk("R13 upd on change", disp_upd, 1);
    @(negedge clk); chk("R13 upd one cycle", disp_upd, 0);
    wr(20'h410, 32'hDEAD_BEEF);
    chk("R13 no upd same value", disp_upd, 0);
    wr(20'h410, 32'h0123_4567);
    chk("R5 digits", disp_chars, hex_chars(32'h0123_4567));
  endtask

  task automatic t_pos;
    logic [63:0] e;
    e = hex_chars(32'h0123_4567);
    wr(20'h41C, 32'h55); chk("R6 misaligned ignored", disp_chars, e);
    chk("R13 no upd ignored", disp_upd, 0);
    wr(20'h418, 32'h141); e[7:0] = 8'h41;
    chk("R6 pos0", disp_chars, e);
    chk("R13 upd pos", disp_upd, 1);
    wr(20'h450, 32'h7A); e[63:56] = 8'h7A;
    chk("R6 pos7", disp_chars, e);
    wr(20'h430, 32'h3F); e[31:24] = 8'h3F;
    chk("R6 pos3", disp_chars, e);
    wr(20'h458, 32'h21); chk("R6 past end ignored", disp_chars, e);
  endtask

  task automatic t_soft;
    wr(20'h500, 32'h42); chk("R7 pulse", sys_rst_req, 1);
    @(negedge clk); chk("R7 pulse ends", sys_rst_req, 0);
    wr(20'h500, 32'h43); chk("R7 other value", sys_rst_req, 0);
    wr(20'h500, 32'h142); chk("R7 exact match", sys_rst_req, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(20'h508, 32'h1FF); chk("R8 brk pin", brk_val, 8'hFF);
    rd(20'h508, d); chk("R8 brk read", d, 32'hFF);
    wr(20'hA00, 32'hABCD); chk("R8 gp pin", gp_out, 8'hCD);
    rd(20'hA00, d); chk("R8 gp read", d, 32'hCD);
    wr(20'hB08, 32'hFF); chk("R9 oe pin", i2c_oe, 2'b11);
    rd(20'hB08, d); chk("R9 oe read", d, 32'h3);
  endtask

  task automatic t_i2c;
    logic [31:0] d;
    wr(20'hB10, 32'hF0F2); chk("R10 scl1 sda0", {i2c_scl, i2c_sda}, 2'b10);
    rd(20'hB10, d); chk("R10 out read", d, 32'hF0F2);
    rd(20'hA08, d); chk("R12 gpi sel=1", d, 32'hF0F2);
    wr(20'hB10, 32'h1); chk("R10 scl0 sda1", {i2c_scl, i2c_sda}, 2'b01);
    wr(20'hB18, 32'h2); chk("R9 sel cleared", i2c_sel, 0);
    rd(20'hB18, d); chk("R9 sel read", d, 0);
    rd(20'hA08, d); chk("R12 gpi sel=0", d, 0);
  endtask

  task automatic t_input;
    logic [31:0] d;
    eeprom_sda = 1'b0;
    rd(20'hB00, d); chk("R11 sda low", d, 32'h2);
    eeprom_sda = 1'b1;
    rd(20'hB00, d); chk("R11 sda high", d, 32'h3);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    rd(20'h408, d); chk("R14 read next cycle", d, 32'hA5);
    wr(20'h408, 32'h11);
    chk("R14 write keeps rdata", bus_rdata, 32'hA5);
    @(negedge clk); chk("R14 idle keeps rdata", bus_rdata, 32'hA5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readonly();
    t_led();
    t_hex();
    t_pos();
    t_soft();
    t_regs();
    t_i2c();
    t_input();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule